// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the configuration that a clock synthesizer's divider logic needs. There are three values: a 9-bit feedback divide value, a 2-bit output divider code and a 2-bit test-select code. They can be set from two sources:

- **Parallel pins.** A load strobe decides whether the outputs follow the pins or keep their last value.
- **Three-wire serial port.** It has a serial clock, serial data and a load line.

Both paths write the same registers. Each path has a transparent phase, in which the outputs track their source, and a latched phase, in which they hold. The serial path can take over from values that the parallel path has latched.

Every input is sampled in one system clock domain. The strobe, the serial clock, the serial load line and the serial data each pass through a two-flop synchronizer. The parallel pins pass through two register stages so that they stay aligned with the control signals. Edges on the control signals are found by comparing the synchronized value with a third, delayed copy. A mode output tells the test logic which load path is in control.

Top module: `divcfg_loader`

## Requirements
- R1: While `par_hold` is low, `m_val` and `n_code` take the values of `par_m` and `par_n` within 4 clock cycles, and `t_sel` keeps its value.
- R2: After `par_hold` rises, `m_val` and `n_code` keep the parallel values latched at the rise. Later changes on `par_m` and `par_n` do not change them while `par_hold` stays high and no serial event occurs.
- R3: While `par_hold` is high, each rising edge of `ser_clk` shifts `ser_dat` into a 14-bit shift register. The first bit lands at the top. The frame is sent in this order: T1, T0, a null bit, N1, N0, then M8 down to M0.
- R4: A rising edge of `ser_load` copies the shift register to the outputs: frame bits 1-2 to `t_sel`, bits 4-5 to `n_code`, bits 6-14 to `m_val`. The null bit (frame bit 3) reaches no output.
- R5: After `ser_load` falls, the outputs hold. Further `ser_clk` edges while `ser_load` is low do not change them.
- R6: While `ser_load` is high and `par_hold` is high, every rising edge of `ser_clk` updates `m_val`, `n_code` and `t_sel` from the shifted register contents.
- R7: A serial load replaces values latched by the parallel path. A falling edge of `par_hold` brings back parallel transparency for `m_val` and `n_code`, and `t_sel` keeps the value loaded serially.
- R8: During reset, `m_val` and `n_code` load from `par_m` and `par_n`, `t_sel` clears to 00 and `ser_mode` is 0.
- R9: `ser_mode` is 1 exactly when the synchronized `par_hold` is high, which is serial mode. It is 0 in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_hold | input | 1 | Parallel load strobe: low means transparent, the rising edge latches |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Serial load: the rising edge transfers, high is transparent, the falling edge latches |
| m_val | output | 9 | Feedback divide value to the dividers |
| n_code | output | 2 | Output divider code |
| t_sel | output | 2 | Test-select code |
| ser_mode | output | 1 | 1 in serial mode, 0 in parallel mode |

## Verification
The assertions check the following on every cycle:
- The outputs follow the staged parallel pins while the strobe is low.
- Each detected serial clock edge enters the synchronized data bit.
- A serial load edge copies the shift register fields.
- The outputs hold in the latched phases.
- The test code is untouched by the parallel path.

Only the bench scenarios can show the end-to-end serial frame order and that the null slot is discarded. The same goes for tracking in the transparent serial phase, and for the hand-over between parallel latching, serial override and the return to parallel mode.

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_hold,
  input  logic [MW-1:0] par_m,
  input  logic [NW-1:0] par_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_load,
  output logic [MW-1:0] m_val,
  output logic [NW-1:0] n_code,
  output logic [TW-1:0] t_sel,
  output logic          ser_mode
);
  localparam int FW = TW + 1 + NW + MW;

  logic [2:0]    pl_q, ck_q, ld_q;
  logic [1:0]    dt_q;
  logic [MW-1:0] pm_q1, pm_q2;
  logic [NW-1:0] pn_q1, pn_q2;
  logic [FW-1:0] shreg;

  wire pl_s     = pl_q[1];
  wire ld_s     = ld_q[1];
  wire dat_s    = dt_q[1];
  wire ck_rise  = ck_q[1] & ~ck_q[2];
  wire ld_rise  = ld_q[1] & ~ld_q[2];
  wire shift_en = ck_rise & pl_s;
  wire [FW-1:0] sh_next = {shreg[FW-2:0], dat_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_q   <= '0;
      ck_q   <= '0;
      ld_q   <= '0;
      dt_q   <= '0;
      pm_q1  <= par_m;
      pm_q2  <= par_m;
      pn_q1  <= par_n;
      pn_q2  <= par_n;
      shreg  <= '0;
      m_val  <= par_m;
      n_code <= par_n;
      t_sel  <= '0;
    end else begin
      pl_q  <= {pl_q[1:0], par_hold};
      ck_q  <= {ck_q[1:0], ser_clk};
      ld_q  <= {ld_q[1:0], ser_load};
      dt_q  <= {dt_q[0], ser_dat};
      pm_q1 <= par_m;
      pm_q2 <= pm_q1;
      pn_q1 <= par_n;
      pn_q2 <= pn_q1;
      if (shift_en) shreg <= sh_next;
      if (!pl_s) begin
        m_val  <= pm_q2;
        n_code <= pn_q2;
      end else if (ld_rise) begin
        t_sel  <= shreg[FW-1 -: TW];
        n_code <= shreg[MW +: NW];
        m_val  <= shreg[MW-1:0];
      end else if (ld_s && ck_rise) begin
        t_sel  <= sh_next[FW-1 -: TW];
        n_code <= sh_next[MW +: NW];
        m_val  <= sh_next[MW-1:0];
      end
    end
  end

  assign ser_mode = pl_s;

  p_par_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> (m_val == $past(pm_q2)) && (n_code == $past(pn_q2)));

  p_par_keeps_t_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> $stable(t_sel));

  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shreg[0] == $past(dat_s));

  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && ld_rise) |=> (m_val == $past(shreg[MW-1:0])) &&
                          (t_sel == $past(shreg[FW-1 -: TW])));

  p_latched_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && !ld_s && !ld_rise) |=> $stable(m_val) && $stable(n_code) && $stable(t_sel));

  p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && ld_s && !ld_rise && ck_rise) |=> m_val == $past(sh_next[MW-1:0]));
endmodule

// File: tb/divcfg_loader_bench.sv
module divcfg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 4;

  logic clk = 0, rst_n = 0;
  logic par_hold = 0, ser_clk = 0, ser_dat = 0, ser_load = 0;
  logic [8:0] par_m = 9'h0A5;
  logic [1:0] par_n = 2'd2;
  logic [8:0] m_val;
  logic [1:0] n_code, t_sel;
  logic ser_mode;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [13:0] sh_model = '0;
  logic [8:0] em; logic [1:0] en, et;

  divcfg_loader u_divcfg_loader (
    .clk(clk), .rst_n(rst_n), .par_hold(par_hold), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load),
    .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .ser_mode(ser_mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] mk_frame(logic [1:0] t, logic nul, logic [1:0] n, logic [8:0] m);
    return {t, nul, n, m};
  endfunction
  function automatic logic [8:0] f_m(logic [13:0] f); return f[8:0]; endfunction
  function automatic logic [1:0] f_n(logic [13:0] f); return f[10:9]; endfunction
  function automatic logic [1:0] f_t(logic [13:0] f); return f[13:12]; endfunction

  task automatic wait_cyc(int k); repeat (k) @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [8:0] m, logic [1:0] n, logic [1:0] t);
    chk({tag, " m"}, 32'(m_val), 32'(m));
    chk({tag, " n"}, 32'(n_code), 32'(n));
    chk({tag, " t"}, 32'(t_sel), 32'(t));
  endtask

  task automatic ser_bit(logic b);
    ser_dat = b; wait_cyc(GAP);
    ser_clk = 1; wait_cyc(GAP);
    ser_clk = 0; wait_cyc(GAP);
    sh_model = {sh_model[12:0], b};
  endtask

  task automatic ser_frame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic ser_pulse;
    ser_load = 1; wait_cyc(GAP);
    ser_load = 0; wait_cyc(GAP);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7411));
    wait_cyc(3);
    // R8: reset loads from pins, test code clear
    chk_all("R8 reset", 9'h0A5, 2'd2, 2'd0);
    chk("R8 mode", 32'(ser_mode), 0);
    rst_n = 1;
    wait_cyc(1);
    chk_all("R8 after release", 9'h0A5, 2'd2, 2'd0);

    // R1: parallel transparency
    for (int i = 0; i < 6; i++) begin
      par_m = 9'($urandom); par_n = 2'($urandom);
      wait_cyc(GAP);
      chk_all("R1 follow", par_m, par_n, 2'd0);
    end
    par_m = 9'h1FF; par_n = 2'd3; wait_cyc(GAP);
    chk_all("R1 all ones", 9'h1FF, 2'd3, 2'd0);

    // R2 / R9: latch on strobe rise
    par_m = 9'd25; par_n = 2'd1; wait_cyc(GAP);
    par_hold = 1; wait_cyc(GAP);
    chk("R9 serial mode", 32'(ser_mode), 1);
    par_m = 9'd300; par_n = 2'd3; wait_cyc(GAP);
    chk_all("R2 latched", 9'd25, 2'd1, 2'd0);

    // R3/R4/R7: serial frame overrides; null bit set high
    ser_frame(mk_frame(2'b10, 1'b1, 2'b01, 9'h0B4));
    chk_all("R5 no load yet", 9'd25, 2'd1, 2'd0);
    ser_pulse();
    chk_all("R4 R7 serial load", 9'h0B4, 2'd1, 2'b10);

    // R5: shifting after latch leaves outputs alone
    for (int i = 0; i < 5; i++) ser_bit(1'($urandom));
    chk_all("R5 hold after fall", 9'h0B4, 2'd1, 2'b10);

    // R3: frame order with distinct fields, null low
    ser_frame(mk_frame(2'b01, 1'b0, 2'b10, 9'h13C));
    ser_pulse();
    chk_all("R3 frame order", 9'h13C, 2'b10, 2'b01);

    // R6: transparent serial with load high
    ser_load = 1; wait_cyc(GAP);
    em = f_m(sh_model); en = f_n(sh_model); et = f_t(sh_model);
    chk_all("R6 load edge", em, en, et);
    for (int i = 0; i < 8; i++) begin
      ser_bit(1'($urandom));
      chk_all("R6 transparent", f_m(sh_model), f_n(sh_model), f_t(sh_model));
    end
    em = f_m(sh_model); en = f_n(sh_model); et = f_t(sh_model);
    ser_load = 0; wait_cyc(GAP);
    ser_bit(~sh_model[0]); ser_bit(1'b1);
    chk_all("R5 after transparent", em, en, et);

    // R7: back to parallel; t keeps serial value
    par_hold = 0; wait_cyc(GAP);
    chk("R9 parallel mode", 32'(ser_mode), 0);
    chk_all("R7 return parallel", 9'd300, 2'd3, et);

    // random mix
    for (int k = 0; k < 20; k++) begin
      logic [13:0] fr;
      par_m = 9'($urandom); par_n = 2'($urandom); wait_cyc(GAP);
      chk_all("R1 random", par_m, par_n, et);
      par_hold = 1; wait_cyc(GAP);
      fr = 14'($urandom);
      ser_frame(fr);
      ser_pulse();
      et = f_t(fr);
      chk_all("R4 random", f_m(fr), f_n(fr), et);
      par_hold = 0; wait_cyc(GAP);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule